// File: doc/BRIEF.md
# Clock-Status Register Bank with Transition Interrupt

This block is the host-facing register window of a telecom clock synchroniser that runs from two redundant references. Four status levels come in from the PLL asynchronously: primary reference lost, secondary reference lost, holdover and unlock. Each level is resynchronised and compared with its value one cycle earlier. Every rising or falling change sets its own sticky bit in a cause byte. While any cause bit is set, an interrupt line stays high. A host read of the cause byte returns the captured bits and clears them in the same access.

The window also holds the configuration bits that drive the PLL and the output stage: operating mode, loop filter width, rate select, automatic switchover enable and trigger, reference alignment, reference and frequency selection, four output enables, a transmit routing byte and an active-low PLL reset. Read-only bytes report a version number and an interrupt line identifier. The host bus is byte wide, with a 3-bit address, a read strobe and a write strobe. Read data is registered and appears the cycle after the strobe.

Top module: `clksync_regbank`

## Requirements
- R1: After reset the bytes read as follows: offset 0 = 0x00, offset 1 = 0x00 (with the active-reference input low), offset 2 = 0x00 (with all status inputs low), offset 3 = 0x00, offset 4 = 0x02 and offset 6 = 0x00. irq_o is low and pll_rst_n_o is high.
- R2: Each status input passes through a two-flop synchroniser. A 0→1 change of a status input sets a cause bit in byte 6, with this bit assignment: bit0 for primary lost, bit2 for secondary lost, bit4 for holdover and bit6 for unlock.
- R3: A 1→0 change of a status input sets the cause bit one position above its rising bit: bit1 for primary lost, bit3 for secondary lost, bit5 for holdover and bit7 for unlock. Both bits of one input can be set at once.
- R4: A read of offset 6 returns the cause bits as they stood before the read and clears them all. irq_o is low after the read if no new change arrived.
- R5: A change detected in the same cycle as the clearing read is not lost. It stays set in the cause byte, and the next read of offset 6 returns it.
- R6: irq_o is high exactly while at least one cause bit is set.
- R7: Offset 2 bits 7..4 read the synchronised live levels: bit7 primary lost, bit6 secondary lost, bit5 holdover, bit4 unlock. Writes to these bits are ignored. Bits 3..0 are read/write and drive out_en_o.
- R8: Offset 0 is read/write and drives these outputs: bit7 hw_sw_en_o, bit6 sw_on_hold_o (1 = trigger on holdover, 0 = trigger on lost clock), bits 5:4 mode_o (00 normal, 01 holdover, 10 free-run), bit3 ref_align_o, bit2 filt_narrow_o (1 = narrow), bits 1:0 rate_o.
- R9: In offset 1, bit0 drives ref_sel_o (0 primary, 1 secondary) and bit1 drives freq_sel_o. Bit3 reads the synchronised active_ref_i. All other bits read 0.
- R10: Offset 4 bit1 drives pll_rst_n_o, and writing 0 there holds the PLL in reset. The other bits of offset 4 read 0.
- R11: Offset 5 reads the VERSION parameter. Offset 7 reads the IRQ_LINE parameter in bits 3..0, with 0 above it. Writes to offsets 5, 6 and 7 have no effect.
- R12: Offset 3 is a read/write byte that drives route_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pri_lost_i | input | 1 | Primary reference lost (async) |
| sec_lost_i | input | 1 | Secondary reference lost (async) |
| holdover_i | input | 1 | PLL in holdover (async) |
| unlock_i | input | 1 | PLL unlocked (async) |
| active_ref_i | input | 1 | Reference currently in use (async) |
| irq_o | output | 1 | Level interrupt |
| hw_sw_en_o | output | 1 | Automatic switchover enable |
| sw_on_hold_o | output | 1 | Switchover trigger select |
| mode_o | output | 2 | PLL operating mode |
| ref_align_o | output | 1 | Reference alignment control |
| filt_narrow_o | output | 1 | Narrow loop filter select |
| rate_o | output | 2 | Rate select |
| ref_sel_o | output | 1 | Redundant reference select |
| freq_sel_o | output | 1 | Reference frequency select |
| out_en_o | output | 4 | Output clock enables |
| route_o | output | 8 | Transmit clock routing |
| pll_rst_n_o | output | 1 | PLL reset, active low |

## Verification
The assertions check four things on every cycle. The interrupt must match the cause byte. A detected change must land in the cause byte on the next edge, including during a clearing read. A clearing read with no concurrent change must leave the cause byte empty. The control outputs and the version byte must not move without a write to their offsets. Only the bench scenarios can show the full path from an asynchronous input change to a specific cause bit position after the synchroniser delay. The same applies to the ordering of several changes before one read, and to the exact read-back encoding of every byte.

// File: rtl/clksync_pkg.sv
package clksync_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int N_STAT = 4;
  localparam int N_CAUSE = 2 * N_STAT;
  localparam int N_OUTEN = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_REFSEL = 3'd1,
    A_OUTEN  = 3'd2,
    A_ROUTE  = 3'd3,
    A_PLLRST = 3'd4,
    A_VER    = 3'd5,
    A_CAUSE  = 3'd6,
    A_IRQID  = 3'd7
  } reg_addr_e;

  // bit positions of offset 0 follow the packed order below
  typedef struct packed {
    logic       hw_sw_en;
    logic       sw_on_hold;
    logic [1:0] mode;
    logic       ref_align;
    logic       filt_narrow;
    logic [1:0] rate;
  } ctrl0_t;
endpackage

// File: rtl/clksync_sync.sv
module clksync_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  // lowest slice is the first stage; requires STAGES >= 2
  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/clksync_edge_cap.sv
module clksync_edge_cap #(
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   lvl,
  input  logic           clr,
  output logic [2*N-1:0] cause,
  output logic [2*N-1:0] set_vec,
  output logic           irq
);
  localparam int NC = 2 * N;

  logic [N-1:0]  prev_q;
  logic [NC-1:0] cause_q;
  logic [NC-1:0] cause_nx;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign set_vec[2*i]   =  lvl[i] & ~prev_q[i];
    assign set_vec[2*i+1] = ~lvl[i] &  prev_q[i];
  end

  // clear first, then merge new changes so none is dropped
  always_comb begin
    cause_nx = clr ? '0 : cause_q;
    cause_nx = cause_nx | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_nx;
      irq_q   <= |cause_nx;
    end
  end

  assign cause = cause_q;
  assign irq   = irq_q;
endmodule

// File: rtl/clksync_ctrl_regs.sv
module clksync_ctrl_regs
  import clksync_pkg::*;
#(
  parameter int OUTEN_W = N_OUTEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output ctrl0_t            ctrl0,
  output logic              ref_sel,
  output logic              freq_sel,
  output logic [OUTEN_W-1:0] out_en,
  output logic [DATA_W-1:0] route,
  output logic              pll_rst_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0     <= '0;
      ref_sel   <= 1'b0;
      freq_sel  <= 1'b0;
      out_en    <= '0;
      route     <= '0;
      pll_rst_n <= 1'b1;
    end else if (wr_en) begin
      case (reg_addr_e'(addr))
        A_CTRL:   ctrl0 <= ctrl0_t'(wdata);
        A_REFSEL: begin
          ref_sel  <= wdata[0];
          freq_sel <= wdata[1];
        end
        A_OUTEN:  out_en    <= wdata[OUTEN_W-1:0];
        A_ROUTE:  route     <= wdata;
        A_PLLRST: pll_rst_n <= wdata[1];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clksync_regbank.sv
module clksync_regbank
  import clksync_pkg::*;
#(
  parameter logic [7:0] VERSION     = 8'h01,
  parameter logic [3:0] IRQ_LINE    = 4'h5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       pri_lost_i,
  input  logic       sec_lost_i,
  input  logic       holdover_i,
  input  logic       unlock_i,
  input  logic       active_ref_i,
  output logic       irq_o,
  output logic       hw_sw_en_o,
  output logic       sw_on_hold_o,
  output logic [1:0] mode_o,
  output logic       ref_align_o,
  output logic       filt_narrow_o,
  output logic [1:0] rate_o,
  output logic       ref_sel_o,
  output logic       freq_sel_o,
  output logic [3:0] out_en_o,
  output logic [7:0] route_o,
  output logic       pll_rst_n_o
);
  localparam int SYNC_W = N_STAT + 1;

  logic [SYNC_W-1:0]  raw_in;
  logic [SYNC_W-1:0]  sync_out;
  logic [N_STAT-1:0]  lvl;
  logic               act_ref;
  logic [N_CAUSE-1:0] cause_q;
  logic [N_CAUSE-1:0] cap_set;
  logic               clr_rd;
  ctrl0_t             ctrl0;
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rdata_q;

  // status index 0 primary, 1 secondary, 2 holdover, 3 unlock
  assign raw_in = {active_ref_i, unlock_i, holdover_i, sec_lost_i, pri_lost_i};

  clksync_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
  );

  assign lvl     = sync_out[N_STAT-1:0];
  assign act_ref = sync_out[N_STAT];
  assign clr_rd  = bus_rd && (reg_addr_e'(bus_addr) == A_CAUSE);

  clksync_edge_cap #(.N(N_STAT)) cap_i (
    .clk(clk), .rst(rst), .lvl(lvl), .clr(clr_rd),
    .cause(cause_q), .set_vec(cap_set), .irq(irq_o)
  );

  clksync_ctrl_regs #(.OUTEN_W(N_OUTEN)) ctl_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl0(ctrl0), .ref_sel(ref_sel_o), .freq_sel(freq_sel_o),
    .out_en(out_en_o), .route(route_o), .pll_rst_n(pll_rst_n_o)
  );

  // live levels are presented with primary in the top bit
  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(bus_addr))
      A_CTRL:   rd_mux = ctrl0;
      A_REFSEL: rd_mux = {4'b0, act_ref, 1'b0, freq_sel_o, ref_sel_o};
      A_OUTEN:  rd_mux = {lvl[0], lvl[1], lvl[2], lvl[3], out_en_o};
      A_ROUTE:  rd_mux = route_o;
      A_PLLRST: rd_mux = {6'b0, pll_rst_n_o, 1'b0};
      A_VER:    rd_mux = VERSION;
      A_CAUSE:  rd_mux = cause_q;
      A_IRQID:  rd_mux = {4'b0, IRQ_LINE};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata     = rdata_q;
  assign hw_sw_en_o    = ctrl0.hw_sw_en;
  assign sw_on_hold_o  = ctrl0.sw_on_hold;
  assign mode_o        = ctrl0.mode;
  assign ref_align_o   = ctrl0.ref_align;
  assign filt_narrow_o = ctrl0.filt_narrow;
  assign rate_o        = ctrl0.rate;
endmodule

// File: rtl/clksync_regbank_chk.sv
module clksync_regbank_chk #(
  parameter logic [7:0] VERSION = 8'h01,
  parameter int         NC      = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [7:0]    bus_rdata,
  input logic          irq_o,
  input logic          pll_rst_n_o,
  input logic [7:0]    ctl_byte,
  input logic [NC-1:0] cause,
  input logic [NC-1:0] set_vec
);
  // R6
  irq_tracks_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == (cause != '0));

  // R5
  change_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd6 && set_vec == '0) |=> (cause == '0 && !irq_o));

  // R10
  pll_rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 3'd4) |=> $stable(pll_rst_n_o));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 3'd0) |=> $stable(ctl_byte));

  // R11
  version_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 3'd5) |=> bus_rdata == VERSION);
endmodule

bind clksync_regbank clksync_regbank_chk #(.VERSION(VERSION), .NC(clksync_pkg::N_CAUSE)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq_o(irq_o), .pll_rst_n_o(pll_rst_n_o),
  .ctl_byte({hw_sw_en_o, sw_on_hold_o, mode_o, ref_align_o, filt_narrow_o, rate_o}),
  .cause(cause_q), .set_vec(cap_set)
);

// File: tb/clksync_regbank_tb_top.sv
`timescale 1ns/1ps
module clksync_regbank_tb_top;
  localparam logic [7:0] VER = 8'h3C;
  localparam logic [3:0] IRQN = 4'h9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic pri = 1'b0, sec = 1'b0, hold = 1'b0, unl = 1'b0, aref = 1'b0;
  logic irq, hw_sw_en, sw_on_hold, ref_align, filt_narrow, ref_sel, freq_sel, pll_rst_n;
  logic [1:0] mode, rate;
  logic [3:0] out_en;
  logic [7:0] route;

  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  clksync_regbank #(.VERSION(VER), .IRQ_LINE(IRQN)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pri_lost_i(pri), .sec_lost_i(sec), .holdover_i(hold), .unlock_i(unl),
    .active_ref_i(aref), .irq_o(irq), .hw_sw_en_o(hw_sw_en),
    .sw_on_hold_o(sw_on_hold), .mode_o(mode), .ref_align_o(ref_align),
    .filt_narrow_o(filt_narrow), .rate_o(rate), .ref_sel_o(ref_sel),
    .freq_sel_o(freq_sel), .out_en_o(out_en), .route_o(route),
    .pll_rst_n_o(pll_rst_n)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expected byte, monitor compares it
  task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() > 0) check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    check({7'b0, irq}, 8'h00, "R1 irq");
    check({7'b0, pll_rst_n}, 8'h01, "R1 pll_rst_n");
    bus_read(3'd0, 8'h00, "R1 off0");
    bus_read(3'd1, 8'h00, "R1 off1");
    bus_read(3'd2, 8'h00, "R1 off2");
    bus_read(3'd3, 8'h00, "R1 off3");
    bus_read(3'd4, 8'h02, "R1 off4");
    bus_read(3'd6, 8'h00, "R1 off6");
    bus_read(3'd5, VER, "R11 version");
    bus_read(3'd7, {4'h0, IRQN}, "R11 irq line");

    // R2 primary rise
    @(negedge clk); pri = 1'b1;
    idle(5);
    check({7'b0, irq}, 8'h01, "R6 irq set");
    bus_read(3'd2, 8'h80, "R7 live primary");
    bus_read(3'd6, 8'h01, "R2 primary rise");
    check({7'b0, irq}, 8'h00, "R4 irq cleared");
    bus_read(3'd6, 8'h00, "R4 cause cleared");

    // R3 primary fall
    @(negedge clk); pri = 1'b0;
    idle(5);
    bus_read(3'd6, 8'h02, "R3 primary fall");

    // several inputs together
    @(negedge clk); sec = 1'b1; hold = 1'b1; unl = 1'b1;
    idle(5);
    bus_read(3'd2, 8'h70, "R7 live levels");
    bus_read(3'd6, 8'h54, "R2 multi rise");
    @(negedge clk); sec = 1'b0; hold = 1'b0; unl = 1'b0;
    idle(5);
    bus_read(3'd6, 8'hA8, "R3 multi fall");

    // both directions before one read
    @(negedge clk); hold = 1'b1;
    idle(5);
    @(negedge clk); hold = 1'b0;
    idle(5);
    bus_read(3'd6, 8'h30, "R3 rise and fall held");

    // R5 change in the clearing cycle
    @(negedge clk); unl = 1'b1;
    @(negedge clk);
    bus_read(3'd6, 8'h00, "R5 read during change");
    check({7'b0, irq}, 8'h01, "R5 irq stays");
    bus_read(3'd6, 8'h40, "R5 change kept");
    check({7'b0, irq}, 8'h00, "R6 irq low");

    // R8 control byte
    bus_write(3'd0, 8'hB6);
    check({hw_sw_en, sw_on_hold, mode, ref_align, filt_narrow, rate}, 8'hB6, "R8 outputs B6");
    bus_read(3'd0, 8'hB6, "R8 readback B6");
    bus_write(3'd0, 8'h49);
    check({hw_sw_en, sw_on_hold, mode, ref_align, filt_narrow, rate}, 8'h49, "R8 outputs 49");

    // R9 reference select
    bus_write(3'd1, 8'hFF);
    check({6'b0, freq_sel, ref_sel}, 8'h03, "R9 sel outputs");
    bus_read(3'd1, 8'h03, "R9 readback");
    @(negedge clk); aref = 1'b1;
    idle(4);
    bus_read(3'd1, 8'h0B, "R9 active ref");

    // R7 enables; top bits ignore writes (unlock still high)
    bus_write(3'd2, 8'hFF);
    check({4'b0, out_en}, 8'h0F, "R7 out_en");
    bus_read(3'd2, 8'h1F, "R7 readback");

    // R12 routing
    bus_write(3'd3, 8'hA5);
    check(route, 8'hA5, "R12 route out");
    bus_read(3'd3, 8'hA5, "R12 readback");

    // R10 PLL reset
    bus_write(3'd4, 8'hFD);
    check({7'b0, pll_rst_n}, 8'h00, "R10 reset asserted");
    bus_read(3'd4, 8'h00, "R10 readback low");
    bus_write(3'd4, 8'h02);
    check({7'b0, pll_rst_n}, 8'h01, "R10 reset released");

    // R11 read-only offsets ignore writes
    bus_write(3'd5, 8'hFF);
    bus_write(3'd6, 8'hFF);
    bus_write(3'd7, 8'hFF);
    check({7'b0, irq}, 8'h00, "R11 no irq from write");
    bus_read(3'd5, VER, "R11 version kept");
    bus_read(3'd6, 8'h00, "R11 cause unchanged");
    bus_read(3'd7, {4'h0, IRQN}, "R11 irq line kept");

    idle(3);
    finish_run();
  end
endmodule